// File: doc/BRIEF.md
# Banked Register File Addressing Unit

This unit resolves every data-memory access of a small 8-bit processor core. An access carries either a 5-bit direct address, which always lands in the first bank or in the shared low region, or the reserved address 00h. That address stands for no storage of its own: it redirects the access through an 8-bit pointer register. The pointer's upper bits pick one of several 32-byte banks and its lower five bits pick the offset inside that bank. Offsets 00h–0Fh are the same locations in every bank. Offsets 10h–1Fh are private to each bank.

The unit holds the general-purpose storage, the pointer register and the status byte, and it enforces the status byte's write rules. The two power-state bits cannot be written. The three arithmetic flag bits are owned by the ALU whenever the ALU reports a new value for them in the same cycle. Reads are combinational from the current contents, so a read that coincides with a write returns the old data.

Top module: `rfa_regfile_top`

## Requirements
- R1: After reset the status byte is 18h: the three page bits and the three flags are 0, and bits 4 and 3 are 1. The pointer, read at offset 04h, returns 0 in every implemented bit and 1 in every unimplemented bit.
- R2: Direct addresses 10h–1Fh reach the same storage as pointer values 10h–1Fh, which is bank 0's private region.
- R3: Offsets 01h–0Fh, other than 03h and 04h, are one common 13-byte store. Direct access and indirect access through any bank reach the same byte.
- R4: An access with direct address 00h goes to the location whose 8-bit address is held in the pointer. Pointer bits 7:5 select the bank and bits 4:0 select the offset, and each bank's offsets 10h–1Fh are distinct storage.
- R5: An indirect access whose effective offset is 00h, in any bank, reads 00h. A write made that way changes no storage, no status bit and no pointer bit.
- R6: The status byte sits at offset 03h and the pointer at offset 04h. Both can be reached directly and, through the common folding, indirectly.
- R7: A write to the status byte loads bits 7:5 and, for any flag without an ALU update, bits 2:0 from the write data. Bits 4:3 stay 1.
- R8: Flag update enables map bit 2 to Z, bit 1 to DC and bit 0 to C. An enabled flag takes the ALU value even when the same cycle writes the status byte, and flags update without any write.
- R9: With BANK_BITS below 3, the unimplemented pointer bits read as 1 and ignore writes. With BANK_BITS=1, writing 00h reads back C0h and writing 35h reads back F5h.
- R10: When read and write hit the same location in one cycle, rd_data shows the old value, and the new value is visible from the next cycle.
- R11: With rd_en low, rd_data is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_addr | input | 5 | Direct address; 00h selects indirect access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| flag_we | input | 3 | Per-flag ALU update enables {Z, DC, C} |
| flag_in | input | 3 | ALU flag values {Z, DC, C} |
| rd_data | output | 8 | Read data, combinational |
| status_out | output | 8 | Current status byte |

## Verification
The bench first writes a distinct byte through the pointer to every address whose offset is neither 03h nor 04h. It then reads every address back, both indirectly and directly. Expected values come from a bench model in which the last writer to each common offset wins, so a bank that fails to fold onto the common region, or a bank that aliases onto another bank, shows up as a wrong byte. Offset-00h addresses tell the null path apart, offset-04h reads must echo the pointer itself, and separate status sequences isolate a plain write, a write combined with flag updates, and flag updates alone. A second instance with one bank bit exposes the unimplemented pointer bits.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
    localparam int DATA_W   = 8;
    localparam int OFS_W    = 5;
    localparam int ROW_W    = 4;
    localparam int COMMON_N = 1 << ROW_W;
    localparam int MAX_BANK_BITS = 3;

    localparam logic [OFS_W-1:0] OFS_NULL   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STATUS = 5'h03;
    localparam logic [OFS_W-1:0] OFS_PTR    = 5'h04;

    localparam logic [DATA_W-1:0] STATUS_RST = 8'h18;

    typedef enum logic [2:0] {
        TK_NULL,
        TK_STATUS,
        TK_PTR,
        TK_COMMON,
        TK_BANKED
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e                 kind;
        logic [MAX_BANK_BITS-1:0]  bank;
        logic [ROW_W-1:0]          row;
    } tgt_t;

    function automatic logic [DATA_W-1:0] impl_mask(input int bank_bits);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < OFS_W + bank_bits);
        end
        return m;
    endfunction

    function automatic tgt_kind_e kind_of(input logic [OFS_W-1:0] ofs);
        if (ofs == OFS_NULL)        return TK_NULL;
        else if (ofs == OFS_STATUS) return TK_STATUS;
        else if (ofs == OFS_PTR)    return TK_PTR;
        else if (!ofs[OFS_W-1])     return TK_COMMON;
        else                        return TK_BANKED;
    endfunction
endpackage

// File: rtl/rfa_addr_decode.sv
module rfa_addr_decode
    import rfa_pkg::*;
#(
    parameter int BANK_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OFS_W-1:0]    dir_addr,
    input  logic [DATA_W-1:0]   ptr_val,
    output tgt_t                tgt
);
    logic [DATA_W-1:0] eff_addr;
    logic [OFS_W-1:0]  eff_ofs;

    always_comb begin
        eff_addr = (dir_addr == OFS_NULL) ? ptr_val : {{(DATA_W-OFS_W){1'b0}}, dir_addr};
        eff_ofs  = eff_addr[OFS_W-1:0];
        tgt      = '0;
        tgt.kind = kind_of(eff_ofs);
        tgt.row  = eff_ofs[ROW_W-1:0];
        if (tgt.kind == TK_BANKED) begin
            tgt.bank[BANK_BITS-1:0] = eff_addr[OFS_W +: BANK_BITS];
        end
    end

    // R2: a non-zero direct address never leaves bank 0
    a_r2_direct_bank0: assert property (@(posedge clk) disable iff (rst)
        (dir_addr != OFS_NULL) |-> (tgt.bank == '0));

    // R3: offsets below 10h never resolve to banked storage
    a_r3_low_is_shared: assert property (@(posedge clk) disable iff (rst)
        (dir_addr != OFS_NULL && !dir_addr[OFS_W-1]) |-> (tgt.kind != TK_BANKED));
endmodule

// File: rtl/rfa_ptr_reg.sv
module rfa_ptr_reg
    import rfa_pkg::*;
#(
    parameter int BANK_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_hit,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   ptr_val
);
    localparam logic [DATA_W-1:0] IMPL = impl_mask(BANK_BITS);

    logic [DATA_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (wr_hit) ptr_q <= wr_data & IMPL;
    end

    assign ptr_val = ptr_q | ~IMPL;

    // R4/R6: a write to the pointer lands in its implemented bits
    a_r4_ptr_written: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> ((ptr_val & IMPL) == ($past(wr_data) & IMPL)));

    // R5: without a hit the pointer holds
    a_r5_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ptr_val));
endmodule

// File: rtl/rfa_status_reg.sv
module rfa_status_reg
    import rfa_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_hit,
    input  logic [2:0]          wr_page,
    input  logic [2:0]          wr_flags,
    input  logic [2:0]          flag_we,
    input  logic [2:0]          flag_in,
    output logic [DATA_W-1:0]   status_q
);
    logic [2:0] page_q;
    logic [1:0] pwr_q;
    logic [2:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= STATUS_RST[7:5];
            pwr_q  <= STATUS_RST[4:3];
        end else if (wr_hit) begin
            page_q <= wr_page;
        end
    end

    for (genvar i = 0; i < 3; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flag_q[i] <= STATUS_RST[i];
            else if (flag_we[i]) flag_q[i] <= flag_in[i];
            else if (wr_hit)     flag_q[i] <= wr_flags[i];
        end

        // R8: an ALU update beats a register write for its flag
        a_r8_flag_override: assert property (@(posedge clk) disable iff (rst)
            flag_we[i] |=> (status_q[i] == $past(flag_in[i])));
    end

    assign status_q = {page_q, pwr_q, flag_q};

    // R7: power-state bits are not writable
    a_r7_pwr_readonly: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (status_q[4:3] == 2'b11));

    // R7: page bits follow the written byte
    a_r7_page_written: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (status_q[7:5] == $past(wr_page)));
endmodule

// File: rtl/rfa_store.sv
module rfa_store
    import rfa_pkg::*;
#(
    parameter int BANK_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  tgt_t                tgt,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_val
);
    localparam int BANKS  = 1 << BANK_BITS;
    localparam int BIDX_W = BANK_BITS + ROW_W;

    logic [DATA_W-1:0] common_mem [COMMON_N];
    logic [DATA_W-1:0] banked_mem [BANKS * COMMON_N];
    logic [BIDX_W-1:0] bidx;

    assign bidx = {tgt.bank[BANK_BITS-1:0], tgt.row};

    always_ff @(posedge clk) begin
        if (wr_en && tgt.kind == TK_COMMON) common_mem[tgt.row] <= wr_data;
        if (wr_en && tgt.kind == TK_BANKED) banked_mem[bidx]    <= wr_data;
    end

    always_comb begin
        case (tgt.kind)
            TK_COMMON: rd_val = common_mem[tgt.row];
            TK_BANKED: rd_val = banked_mem[bidx];
            default:   rd_val = '0;
        endcase
    end

    // R10: written byte is present one cycle after the write
    a_r10_banked_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt.kind == TK_BANKED) |=> (banked_mem[$past(bidx)] == $past(wr_data)));

    a_r3_common_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt.kind == TK_COMMON) |=> (common_mem[$past(tgt.row)] == $past(wr_data)));
endmodule

// File: rtl/rfa_regfile_top.sv
module rfa_regfile_top
    import rfa_pkg::*;
#(
    parameter int BANK_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OFS_W-1:0]    dir_addr,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [2:0]          flag_we,
    input  logic [2:0]          flag_in,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   status_out
);
    tgt_t              tgt;
    logic [DATA_W-1:0] ptr_val;
    logic [DATA_W-1:0] store_val;
    logic              status_hit;
    logic              ptr_hit;

    assign status_hit = wr_en && (tgt.kind == TK_STATUS);
    assign ptr_hit    = wr_en && (tgt.kind == TK_PTR);

    rfa_addr_decode #(.BANK_BITS(BANK_BITS)) dec_i (
        .clk      (clk),
        .rst      (rst),
        .dir_addr (dir_addr),
        .ptr_val  (ptr_val),
        .tgt      (tgt)
    );

    rfa_ptr_reg #(.BANK_BITS(BANK_BITS)) ptr_i (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (ptr_hit),
        .wr_data (wr_data),
        .ptr_val (ptr_val)
    );

    rfa_status_reg stat_i (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (status_hit),
        .wr_page  (wr_data[7:5]),
        .wr_flags (wr_data[2:0]),
        .flag_we  (flag_we),
        .flag_in  (flag_in),
        .status_q (status_out)
    );

    rfa_store #(.BANK_BITS(BANK_BITS)) store_i (
        .clk     (clk),
        .rst     (rst),
        .tgt     (tgt),
        .wr_en   (wr_en),
        .wr_data (wr_data[DATA_W-1:0]),
        .rd_val  (store_val)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (tgt.kind)
                TK_STATUS: rd_data = status_out;
                TK_PTR:    rd_data = ptr_val;
                TK_COMMON,
                TK_BANKED: rd_data = store_val;
                default:   rd_data = '0;
            endcase
        end
    end

    // R5: a null write leaves pointer and status untouched
    a_r5_null_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tgt.kind == TK_NULL && flag_we == 3'b000) |=>
            ($stable(ptr_val) && $stable(status_out)));

    // R11: idle read port is quiet
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    // R9: unimplemented pointer bits always read as one
    a_r9_ptr_fill: assert property (@(posedge clk) disable iff (rst)
        (rd_en && tgt.kind == TK_PTR) |-> ((rd_data | impl_mask(BANK_BITS)) == 8'hFF));
endmodule

// File: tb/rfa_regfile_top_tb_top.sv
`timescale 1ns/1ps
module rfa_regfile_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] dir_addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flag_we = '0, flag_in = '0;
    logic [7:0] rd_data, status_out;

    logic [4:0] b_addr = '0;
    logic       b_rd = 1'b0, b_wr = 1'b0;
    logic [7:0] b_wdata = '0;
    logic [7:0] b_rdata, b_status;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [256];

    always #5 clk = ~clk;

    rfa_regfile_top #(.BANK_BITS(3)) dut_i (
        .clk(clk), .rst(rst), .dir_addr(dir_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .flag_we(flag_we), .flag_in(flag_in),
        .rd_data(rd_data), .status_out(status_out)
    );

    rfa_regfile_top #(.BANK_BITS(1)) dut_b (
        .clk(clk), .rst(rst), .dir_addr(b_addr), .rd_en(b_rd), .wr_en(b_wr),
        .wr_data(b_wdata), .flag_we(3'b000), .flag_in(3'b000),
        .rd_data(b_rdata), .status_out(b_status)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        dir_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        dir_addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    function automatic int phys(input int a);
        return ((a & 8'h10) == 0) ? (a & 8'h0F) : a;
    endfunction

    initial begin : wd
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check("R1 status", status_out, 8'h18);
        rd(5'h04, v); check("R1 ptr", v, 8'h00);
        @(negedge clk); b_addr = 5'h04; b_rd = 1'b1; #1 check("R1 ptr narrow", b_rdata, 8'hC0); b_rd = 1'b0;
        // R11
        @(negedge clk); dir_addr = 5'h04; #1 check("R11 idle", rd_data, 8'h00);

        // R4/R5/R3: indirect write sweep
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        for (int a = 0; a < 256; a++) begin
            if ((a & 5'h1F) == 3 || (a & 5'h1F) == 4) continue;
            wr(5'h04, 8'(a));
            wr(5'h00, 8'(a ^ 8'hA5));
            if ((a & 5'h1F) != 0) model[phys(a)] = 8'(a ^ 8'hA5);
        end
        check("R5 null write left status", status_out, 8'h18);
        // indirect read-back of every address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] exp;
            wr(5'h04, 8'(a));
            rd(5'h00, v);
            case (a & 5'h1F)
                0: exp = 8'h00;
                3: exp = 8'h18;
                4: exp = 8'(a);
                default: exp = model[phys(a)];
            endcase
            if ((a & 5'h1F) == 0)      check("R5 null read", v, exp);
            else if ((a & 5'h1F) < 16) check("R3 common fold", v, exp);
            else                       check("R4 banked", v, exp);
        end
        // R2/R3/R6 direct reads
        for (int a = 1; a < 32; a++) begin
            logic [7:0] exp;
            rd(5'(a), v);
            exp = (a == 3) ? 8'h18 : (a == 4) ? 8'hFF : model[phys(a)];
            if (a >= 16) check("R2 direct bank0", v, exp);
            else         check("R6/R3 direct low", v, exp);
        end

        // R7 status writes
        wr(5'h03, 8'hE7); check("R7 write all", status_out, 8'hFF);
        wr(5'h03, 8'h00); check("R7 clear", status_out, 8'h18);
        // R8 clear with Z update: 000 11 100
        @(negedge clk); dir_addr = 5'h03; wr_data = 8'h00; wr_en = 1'b1; flag_we = 3'b100; flag_in = 3'b100;
        wr(5'h03, 8'h07);
        // second call above overlaps: flags still enabled on the first edge
        flag_we = 3'b000;
        @(negedge clk); wr_en = 1'b0;
        check("R7 bits-from-data", status_out, 8'h1F);
        @(negedge clk); dir_addr = 5'h03; wr_data = 8'h00; wr_en = 1'b1; flag_we = 3'b100; flag_in = 3'b100;
        @(negedge clk); wr_en = 1'b0; flag_we = 3'b000;
        check("R8 clear with Z", status_out, 8'h1C);
        @(negedge clk); flag_we = 3'b011; flag_in = 3'b001;
        @(negedge clk); flag_we = 3'b000;
        check("R8 flag only", status_out, 8'h1D);
        @(negedge clk); dir_addr = 5'h03; wr_data = 8'hA2; wr_en = 1'b1; flag_we = 3'b010; flag_in = 3'b000;
        @(negedge clk); wr_en = 1'b0; flag_we = 3'b000;
        check("R8 DC wins", status_out, 8'hB8);
        // R6 indirect status through bank 5
        wr(5'h04, 8'hA3); rd(5'h00, v); check("R6 status indirect", v, 8'hB8);

        // R10 read-before-write
        wr(5'h15, 8'h11);
        @(negedge clk); dir_addr = 5'h15; wr_data = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
        #1 check("R10 old data", rd_data, 8'h11);
        @(negedge clk); wr_en = 1'b0;
        #1 check("R10 new data", rd_data, 8'h99);
        rd_en = 1'b0;

        // R9 narrow pointer
        @(negedge clk); b_addr = 5'h04; b_wdata = 8'h35; b_wr = 1'b1;
        @(negedge clk); b_wr = 1'b0; b_rd = 1'b1;
        #1 check("R9 ptr 35", b_rdata, 8'hF5);
        b_rd = 1'b0;
        @(negedge clk); b_wdata = 8'hFF; b_wr = 1'b1;
        @(negedge clk); b_wr = 1'b0; b_rd = 1'b1;
        #1 check("R9 ptr FF", b_rdata, 8'hFF);
        b_rd = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule